// File: doc/BRIEF.md
# Seven-Slot LVDS Pixel Serializer

The block turns one parallel pixel per pixel period into serial bit streams for a flat-panel link. Each pixel carries 8-bit red, green and blue plus horizontal sync, vertical sync and data-enable. The block packs them into seven bit slots on each of four data lanes. It also drives a clock lane whose level follows the slot position. The block runs on a fast clock at seven times the pixel rate. A one-in-seven strobe marks the cycle in which a new pixel is taken in and slot 0 begins.

A static selector picks one of three colour-to-slot layouts. The first is a narrow layout: 6 bits per colour on three lanes. The other two are wide layouts: 8 bits per colour on four lanes. They differ in which colour bits go to the fourth lane: the two lowest bits or the two highest bits. A mirror input makes every data lane send its seven slots in reverse order. The selector and mirror are sampled only on the strobe cycle, so each pixel is sent whole under one layout. Serial data leaves the block one pixel period after the pixel is captured.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: Each data lane sends one bit per fast-clock cycle, seven slots per pixel. The slot counter runs 0 to 6 and wraps to 0. When the strobe is high, the output after that edge is slot 0. If no strobe arrives after slot 6, the same seven-bit word is sent again.
- R2: The clock lane is low in slots 2, 3 and 4 and high in slots 0, 1, 5 and 6.
- R3: With `map_sel` = 0 (or the spare code 3), the narrow layout is used. Slot 0 comes first in each list. Lane 0 sends G0,R5,R4,R3,R2,R1,R0. Lane 1 sends B1,B0,G5,G4,G3,G2,G1. Lane 2 sends DE,VS,HS,B5,B4,B3,B2. Lane 3 stays low in every slot.
- R4: With `map_sel` = 1, lane 3 carries the low bits. Lane 0 sends G2,R7..R2. Lane 1 sends B3,B2,G7..G3. Lane 2 sends DE,VS,HS,B7..B4. Lane 3 sends 0,B1,B0,G1,G0,R1,R0.
- R5: With `map_sel` = 2, lanes 0 to 2 match R3. Lane 3 sends 0,B7,B6,G7,G6,R7,R6.
- R6: In every layout, the control slots hold data-enable, then vertical sync, then horizontal sync, in slots 0, 1 and 2 of lane 2. In both wide layouts, slot 0 of lane 3 is always 0.
- R7: With `mirror` high, each data lane sends the slot-6 bit first and the slot-0 bit last. Lane 3 in the narrow layout stays low.
- R8: `map_sel`, `mirror` and the pixel inputs are sampled only in the strobe cycle. Changes in other cycles do not affect any pixel.
- R9: A pixel captured at one strobe edge is sent, starting with slot 0, from the next strobe edge on. That is a latency of one pixel period.
- R10: A synchronous active-high reset drives all data lanes low, sets the clock lane high (slot 0) and clears the slot counter. The pending pixel is cleared, so the first word sent after reset is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast (bit-rate) clock |
| rst | input | 1 | synchronous active-high reset |
| pix_stb | input | 1 | one-in-seven strobe: capture pixel, start slot 0 |
| pix_r | input | 8 | red component |
| pix_g | input | 8 | green component |
| pix_b | input | 8 | blue component |
| pix_hs | input | 1 | horizontal sync |
| pix_vs | input | 1 | vertical sync |
| pix_de | input | 1 | data enable |
| map_sel | input | 2 | layout select: 0/3 narrow, 1 wide low-bits lane 3, 2 wide high-bits lane 3 |
| mirror | input | 1 | reverse slot order on all data lanes |
| lane_data | output | 4 | serial data lanes, registered |
| lane_clk | output | 1 | clock-lane level, registered |

## Verification
The bench builds the block at its package defaults: seven slots, four lanes and 8-bit colour. The wire format fixes these values, and with them every slot of every lane is visible at the ports. The bench rebuilds each lane's seven-bit word over a pixel period. It compares that word with a model of all four selector codes, with mirror both off and on. It also changes the selector, mirror and pixel inputs during the slots between strobes to show that only the strobe cycle counts. Gaps with no strobe show the word repeating. A reset in mid-stream shows the cleared pending word.

// File: rtl/pxser_pkg.sv
package pxser_pkg;
  localparam int SLOTS    = 7;
  localparam int LANES    = 4;
  localparam int CW       = 8;
  localparam int SW       = $clog2(SLOTS);
  localparam int CLK_LO_A = 2;
  localparam int CLK_LO_B = 4;

  typedef logic [SLOTS-1:0] slot_word_t;

  typedef enum logic [1:0] {
    MAP_NARROW   = 2'd0,
    MAP_WIDE_LO  = 2'd1,
    MAP_WIDE_HI  = 2'd2,
    MAP_NARROW_X = 2'd3
  } map_e;

  function automatic logic clk_level(input logic [SW-1:0] slot);
    return !((int'(slot) >= CLK_LO_A) && (int'(slot) <= CLK_LO_B));
  endfunction
endpackage

// File: rtl/pxser_mapper.sv
module pxser_mapper
  import pxser_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  map_sel,
  input  logic                        mirror,
  input  logic [CW-1:0]               r,
  input  logic [CW-1:0]               g,
  input  logic [CW-1:0]               b,
  input  logic                        hs,
  input  logic                        vs,
  input  logic                        de,
  output logic [LANES-1:0][SLOTS-1:0] tx_words
);
  // nat[l][s] is the bit for slot s in natural order
  logic [LANES-1:0][SLOTS-1:0] nat;

  always_comb begin
    nat = '0;
    unique case (map_e'(map_sel))
      MAP_WIDE_LO: begin
        nat[0] = {r[2], r[3], r[4], r[5], r[6], r[7], g[2]};
        nat[1] = {g[3], g[4], g[5], g[6], g[7], b[2], b[3]};
        nat[2] = {b[4], b[5], b[6], b[7], hs, vs, de};
        nat[3] = {r[0], r[1], g[0], g[1], b[0], b[1], 1'b0};
      end
      MAP_WIDE_HI: begin
        nat[0] = {r[0], r[1], r[2], r[3], r[4], r[5], g[0]};
        nat[1] = {g[1], g[2], g[3], g[4], g[5], b[0], b[1]};
        nat[2] = {b[2], b[3], b[4], b[5], hs, vs, de};
        nat[3] = {r[6], r[7], g[6], g[7], b[6], b[7], 1'b0};
      end
      default: begin
        nat[0] = {r[0], r[1], r[2], r[3], r[4], r[5], g[0]};
        nat[1] = {g[1], g[2], g[3], g[4], g[5], b[0], b[1]};
        nat[2] = {b[2], b[3], b[4], b[5], hs, vs, de};
        nat[3] = '0;
      end
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign tx_words[l][s] = mirror ? nat[l][SLOTS-1-s] : nat[l][s];
    end
  end

  // R3 / R7: narrow layout keeps the fourth lane quiet in either order
  p_lane3_low_r3: assert property (@(posedge clk) disable iff (rst)
    (map_sel == 2'd0 || map_sel == 2'd3) |-> (tx_words[LANES-1] == '0));

  // R6: reserved control slot of the fourth lane is zero in wide layouts
  p_ctl3_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (map_sel == 2'd1 || map_sel == 2'd2) |->
      ((mirror ? tx_words[LANES-1][SLOTS-1] : tx_words[LANES-1][0]) == 1'b0));
endmodule

// File: rtl/pxser_slot_seq.sv
module pxser_slot_seq
  import pxser_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  output logic [SW-1:0] slot_nxt,
  output logic [SW-1:0] slot_q,
  output logic          lane_clk
);
  always_comb begin
    if (stb)                              slot_nxt = '0;
    else if (slot_q == SW'(SLOTS - 1))    slot_nxt = '0;
    else                                  slot_nxt = slot_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= '0;
      lane_clk <= 1'b1;
    end else begin
      slot_q   <= slot_nxt;
      lane_clk <= clk_level(slot_nxt);
    end
  end

  p_slot_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (!stb && slot_q == SW'(SLOTS - 1)) |=> (slot_q == '0));

  p_stb_restart_r1: assert property (@(posedge clk) disable iff (rst)
    stb |=> (slot_q == '0));

  p_slot_range_r1: assert property (@(posedge clk) disable iff (rst)
    int'(slot_q) < SLOTS);

  p_clk_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(lane_clk) |-> (slot_q == SW'(CLK_LO_A)));

  p_clk_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(lane_clk) |-> (slot_q == SW'(CLK_LO_B + 1) || slot_q == '0));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (slot_q == '0 && lane_clk));
endmodule

// File: rtl/pxser_lane_tx.sv
module pxser_lane_tx
  import pxser_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  slot_word_t    word_in,
  input  logic [SW-1:0] slot_nxt,
  output logic          bit_q
);
  slot_word_t pend_q;
  slot_word_t cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      cur_q  <= '0;
      bit_q  <= 1'b0;
    end else if (stb) begin
      pend_q <= word_in;
      cur_q  <= pend_q;
      bit_q  <= pend_q[0];
    end else begin
      bit_q  <= cur_q[slot_nxt];
    end
  end

  // R8: the word on the wire never changes between strobes
  p_word_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(cur_q));

  p_pend_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(pend_q));

  p_lane_reset_r10: assert property (@(posedge clk)
    rst |=> (bit_q == 1'b0));
endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
  import pxser_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_stb,
  input  logic [CW-1:0]    pix_r,
  input  logic [CW-1:0]    pix_g,
  input  logic [CW-1:0]    pix_b,
  input  logic             pix_hs,
  input  logic             pix_vs,
  input  logic             pix_de,
  input  logic [1:0]       map_sel,
  input  logic             mirror,
  output logic [LANES-1:0] lane_data,
  output logic             lane_clk
);
  logic [LANES-1:0][SLOTS-1:0] tx_words;
  logic [SW-1:0]               slot_nxt;
  logic [SW-1:0]               slot_q;

  pxser_mapper u_map (
    .clk      (clk),
    .rst      (rst),
    .map_sel  (map_sel),
    .mirror   (mirror),
    .r        (pix_r),
    .g        (pix_g),
    .b        (pix_b),
    .hs       (pix_hs),
    .vs       (pix_vs),
    .de       (pix_de),
    .tx_words (tx_words)
  );

  pxser_slot_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .stb      (pix_stb),
    .slot_nxt (slot_nxt),
    .slot_q   (slot_q),
    .lane_clk (lane_clk)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_tx
    pxser_lane_tx u_tx (
      .clk      (clk),
      .rst      (rst),
      .stb      (pix_stb),
      .word_in  (tx_words[l]),
      .slot_nxt (slot_nxt),
      .bit_q    (lane_data[l])
    );
  end

  // R9: slot 0 of a new word is on the lanes right after every strobe
  p_slot0_after_stb_r9: assert property (@(posedge clk) disable iff (rst)
    pix_stb |=> (slot_q == '0 && lane_clk));
endmodule

// File: tb/lvds_pixel_serializer_test.sv
module lvds_pixel_serializer_test;
  localparam int CLK_P = 10;
  localparam logic [6:0] CLK_PAT = 7'b1100011;

  logic       clk = 1'b0;
  logic       rst;
  logic       pix_stb;
  logic [7:0] pix_r, pix_g, pix_b;
  logic       pix_hs, pix_vs, pix_de;
  logic [1:0] map_sel;
  logic       mirror;
  logic [3:0] lane_data;
  logic       lane_clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;
  logic [6:0] prev_exp [4];

  always #(CLK_P/2) clk = ~clk;

  lvds_pixel_serializer uut (
    .clk(clk), .rst(rst), .pix_stb(pix_stb),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de),
    .map_sel(map_sel), .mirror(mirror),
    .lane_data(lane_data), .lane_clk(lane_clk)
  );

  // expected slot word, bit s = slot s on the wire (R3 R4 R5 R6 R7)
  function automatic logic [6:0] ref_lane(int ln, logic [7:0] r, logic [7:0] g,
      logic [7:0] b, logic hs, logic vs, logic de, logic [1:0] ms, logic mir);
    logic [6:0] w;
    logic [6:0] o;
    logic [7:0] rr, gg, bb;
    w  = '0;
    rr = (ms == 2'd1) ? (r >> 2) : r;
    gg = (ms == 2'd1) ? (g >> 2) : g;
    bb = (ms == 2'd1) ? (b >> 2) : b;
    if (ln == 3) begin
      if (ms == 2'd1) begin
        w[1] = b[1]; w[2] = b[0]; w[3] = g[1]; w[4] = g[0]; w[5] = r[1]; w[6] = r[0];
      end else if (ms == 2'd2) begin
        w[1] = b[7]; w[2] = b[6]; w[3] = g[7]; w[4] = g[6]; w[5] = r[7]; w[6] = r[6];
      end
    end else if (ln == 0) begin
      w[0] = gg[0];
      for (int k = 1; k < 7; k++) w[k] = rr[6-k];
    end else if (ln == 1) begin
      w[0] = bb[1]; w[1] = bb[0];
      for (int k = 2; k < 7; k++) w[k] = gg[7-k];
    end else begin
      w[0] = de; w[1] = vs; w[2] = hs;
      for (int k = 3; k < 7; k++) w[k] = bb[8-k];
    end
    o = w;
    if (mir) for (int k = 0; k < 7; k++) o[k] = w[6-k];
    return o;
  endfunction

  task automatic check(bit ok, string tag, logic [6:0] got, logic [6:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %b exp %b", tag, got, exp);
    end
  endtask

  task automatic scramble();
    map_sel = 2'($urandom);
    mirror  = 1'($urandom);
    pix_r   = 8'($urandom);
    pix_g   = 8'($urandom);
    pix_b   = 8'($urandom);
    {pix_hs, pix_vs, pix_de} = 3'($urandom);
  endtask

  // receive one seven-slot period; entered and left at a negedge
  task automatic grab(output logic [6:0] rcv [4], output logic [6:0] ck, input bit scr);
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      pix_stb = 1'b0;
      for (int l = 0; l < 4; l++) rcv[l][s] = lane_data[l];
      ck[s] = lane_clk;
      if (scr) scramble();   // R8: mid-pixel changes must be ignored
    end
  endtask

  task automatic run_pixel(logic [7:0] r, logic [7:0] g, logic [7:0] b,
      logic hs, logic vs, logic de, logic [1:0] ms, logic mir, bit scr, bit idle);
    logic [6:0] nxt [4];
    logic [6:0] rcv [4];
    logic [6:0] ck;
    string tag;
    pix_r = r; pix_g = g; pix_b = b;
    pix_hs = hs; pix_vs = vs; pix_de = de;
    map_sel = ms; mirror = mir; pix_stb = 1'b1;
    for (int l = 0; l < 4; l++) nxt[l] = ref_lane(l, r, g, b, hs, vs, de, ms, mir);
    grab(rcv, ck, scr);
    for (int l = 0; l < 4; l++) begin
      tag = $sformatf("R9 R6 R8 lane %0d", l);
      check(rcv[l] === prev_exp[l], tag, rcv[l], prev_exp[l]);
    end
    check(ck === CLK_PAT, "R2 clock lane", ck, CLK_PAT);
    if (idle) begin
      // R1: no strobe after slot 6, the same word is sent again
      grab(rcv, ck, 1'b0);
      for (int l = 0; l < 4; l++)
        check(rcv[l] === prev_exp[l], "R1 repeat without strobe", rcv[l], prev_exp[l]);
      check(ck === CLK_PAT, "R1 R2 clock on repeat", ck, CLK_PAT);
    end
    for (int l = 0; l < 4; l++) prev_exp[l] = nxt[l];
  endtask

  // flush: send a dummy pixel so the previous word is compared, tagged per mode
  task automatic run_mode_pixel(logic [7:0] r, logic [7:0] g, logic [7:0] b,
      logic [2:0] ctl, logic [1:0] ms, logic mir);
    logic [6:0] rcv [4];
    logic [6:0] ck;
    logic [6:0] e;
    string tag;
    run_pixel(r, g, b, ctl[2], ctl[1], ctl[0], ms, mir, 1'b0, 1'b0);
    pix_stb = 1'b1;
    grab(rcv, ck, 1'b0);
    for (int l = 0; l < 4; l++) begin
      e = prev_exp[l];
      if (mir)              tag = $sformatf("R7 mode %0d lane %0d", ms, l);
      else if (ms == 2'd1)  tag = $sformatf("R4 lane %0d", l);
      else if (ms == 2'd2)  tag = $sformatf("R5 lane %0d", l);
      else                  tag = $sformatf("R3 mode %0d lane %0d", ms, l);
      check(rcv[l] === e, tag, rcv[l], e);
    end
    // the flush strobe captured the same pixel again
    for (int l = 0; l < 4; l++)
      prev_exp[l] = ref_lane(l, pix_r, pix_g, pix_b, pix_hs, pix_vs, pix_de, map_sel, mirror);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pix_stb = 1'b0;
    @(negedge clk);
    n_chk++;
    if (lane_data !== 4'b0 || lane_clk !== 1'b1) begin
      n_bad++;
      $display("FAIL R10 reset state got data %b clk %b exp data 0000 clk 1", lane_data, lane_clk);
    end
    @(negedge clk);
    rst = 1'b0;
    for (int l = 0; l < 4; l++) prev_exp[l] = '0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    rst = 1'b1; pix_stb = 1'b0;
    pix_r = '0; pix_g = '0; pix_b = '0;
    pix_hs = 0; pix_vs = 0; pix_de = 0;
    map_sel = 2'd0; mirror = 1'b0;
    for (int l = 0; l < 4; l++) prev_exp[l] = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (lane_data !== 4'b0 || lane_clk !== 1'b1) begin
      n_bad++;
      $display("FAIL R10 initial reset got data %b clk %b exp data 0000 clk 1", lane_data, lane_clk);
    end
    rst = 1'b0;

    // directed: every selector code, both orders, edge patterns
    for (int m = 0; m < 4; m++) begin
      for (int mi = 0; mi < 2; mi++) begin
        run_mode_pixel(8'hFF, 8'hFF, 8'hFF, 3'b111, 2'(m), 1'(mi));
        run_mode_pixel(8'hA5, 8'h3C, 8'h96, 3'b101, 2'(m), 1'(mi));
        run_mode_pixel(8'h01, 8'h80, 8'h40, 3'b010, 2'(m), 1'(mi));
      end
    end

    // R1: strobe gap, word repeats
    run_pixel(8'h5A, 8'hC3, 8'h18, 1, 0, 1, 2'd1, 1'b0, 1'b0, 1'b1);
    run_pixel(8'h00, 8'hFF, 8'h0F, 0, 1, 0, 2'd2, 1'b1, 1'b0, 1'b1);

    // R10: reset mid-stream clears pending word
    run_pixel(8'hFF, 8'hFF, 8'hFF, 1, 1, 1, 2'd1, 1'b0, 1'b0, 1'b0);
    do_reset();
    run_pixel(8'h12, 8'h34, 8'h56, 1, 0, 0, 2'd2, 1'b0, 1'b0, 1'b0);

    // random stream with mid-pixel scrambling (R8) and gaps (R1)
    for (int i = 0; i < 300; i++) begin
      run_pixel(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                ($urandom % 10) == 0);
    end
    pix_stb = 1'b1;
    begin
      logic [6:0] rcv [4];
      logic [6:0] ck;
      grab(rcv, ck, 1'b0);
      for (int l = 0; l < 4; l++)
        check(rcv[l] === prev_exp[l], "R9 final word", rcv[l], prev_exp[l]);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule